// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Per-Pin Edge Interrupts

This block is a general-purpose I/O port of sixteen pins behind a small 16-bit register port. Each pin is set as an input or an output. Output pins drive a stored value. Input pins are sampled on every clock. A sampled input can raise a sticky status bit when it sees the edge chosen for it, either rising or falling. The status bits are combined into a single interrupt line.

Software sets up a pin by writing its direction, its edge polarity and its mask bit. It then waits for the interrupt, reads the status register and clears the bits it has handled by writing ones to them. Reads of the input levels pass through a per-pin enable gate. Requests that are not 16 bits wide have no effect on any register.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the register values are: stored output value 0xFFFF, direction 0xFFFF (all inputs), edge polarity 0xFFFF, mask 0xFFFF, status 0x0000, pin enable 0xFFFF and sampled levels 0x0000. `irq` is low and `pin_oe` is 0x0000.
- R2: A direction bit (offset 0x08) of 1 makes its pin an input, with `pin_oe` low for that pin. A direction bit of 0 makes its pin an output, with `pin_oe` high for that pin.
- R3: The stored output value (offset 0x04) is readable. `pin_out` carries the stored bit on output pins and 0 on input pins. Turning a pin to an output drives its stored value again, with no rewrite of the output register.
- R4: For an edge-polarity bit (offset 0x0C) of 1, a 0→1 change on an armed input pin sets its status bit. The status bit is visible after the first rising clock edge that samples the new level.
- R5: For an edge-polarity bit of 0, a 1→0 change on an armed input pin sets its status bit. The edge of the opposite direction sets nothing.
- R6: A pin is armed only when its direction bit is 1 and its mask bit (offset 0x10) is 0. A mask bit of 1 masks the pin. Pins that are outputs or masked never set a status bit.
- R7: Writing the status register (offset 0x14) clears each bit written as 1 and keeps the others. When a bit is set and cleared in the same cycle, the new event wins and the bit stays set.
- R8: `irq` is high exactly when at least one status bit is set. It rises together with the first status bit and falls in the cycle in which the last set bit is cleared.
- R9: A read of offset 0x00 returns the sampled pin levels ANDed with the pin-enable register (offset 0x18).
- R10: Writes to offset 0x00, writes to undefined offsets and any request whose `req_size` is not 1 (16-bit) leave all registers unchanged. Reads of undefined offsets, and reads whose width is not 16 bits, return 0.
- R11: Read data appears on `rdata` after the rising clock edge that accepts the read request. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Synchronous pin levels |
| pin_out | output | 16 | Driven pin values (0 on input pins) |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the port with its default parameters: sixteen pins and an eight-bit offset. That is small enough to sweep every pin through all eight combinations of polarity, direction and mask. For each combination it fires the selected edge and then the opposite edge, and it computes the expected status word as a one-hot shift of the pin index. The same configuration also reaches the set-versus-clear collision, the re-drive on a change of direction, and the ignored writes: those sent to the read-only offset, to an undefined offset, and with the wrong width.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int ADDR_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ACC_8   = 2'd0,
        ACC_16  = 2'd1,
        ACC_32  = 2'd2,
        ACC_RSV = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_DRIVE,
        SEL_DIR,
        SEL_POL,
        SEL_MASK,
        SEL_STAT,
        SEL_GATE
    } reg_sel_e;

    localparam addr_t OFS_LEVEL = 8'h00;
    localparam addr_t OFS_DRIVE = 8'h04;
    localparam addr_t OFS_DIR   = 8'h08;
    localparam addr_t OFS_POL   = 8'h0C;
    localparam addr_t OFS_MASK  = 8'h10;
    localparam addr_t OFS_STAT  = 8'h14;
    localparam addr_t OFS_GATE  = 8'h18;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } acc_t;

    function automatic reg_sel_e decode_ofs(addr_t a);
        reg_sel_e s;
        case (a)
            OFS_LEVEL: s = SEL_LEVEL;
            OFS_DRIVE: s = SEL_DRIVE;
            OFS_DIR:   s = SEL_DIR;
            OFS_POL:   s = SEL_POL;
            OFS_MASK:  s = SEL_MASK;
            OFS_STAT:  s = SEL_STAT;
            OFS_GATE:  s = SEL_GATE;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_acc_decode.sv
module gpio_acc_decode
    import gpio_edge_pkg::*;
(
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [1:0]   req_size,
    input  addr_t        req_addr,
    output acc_t         acc,
    output logic         rd_any
);
    logic size_ok;

    always_comb begin
        size_ok = (acc_size_e'(req_size) == ACC_16);
        acc.sel = decode_ofs(req_addr);
        acc.wr  = req_valid & req_write & size_ok & (acc.sel != SEL_NONE)
                  & (acc.sel != SEL_LEVEL);
        acc.rd  = req_valid & ~req_write & size_ok;
        rd_any  = req_valid & ~req_write;
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] drive_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] pol_q,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] gate_q
);
    localparam logic [NPINS-1:0] ONES = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= ONES;
            dir_q   <= ONES;
            pol_q   <= ONES;
            mask_q  <= ONES;
            gate_q  <= ONES;
        end else if (acc.wr) begin
            case (acc.sel)
                SEL_DRIVE: drive_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_POL:   pol_q   <= wdata;
                SEL_MASK:  mask_q  <= wdata;
                SEL_GATE:  gate_q  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int NPINS = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] arm,
    output logic [NPINS-1:0] level_q,
    output logic [NPINS-1:0] hit
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise;
        logic fall;

        always_ff @(posedge clk) begin
            if (rst) level_q[i] <= 1'b0;
            else     level_q[i] <= pin_in[i];
        end

        assign rise   = pin_in[i] & ~level_q[i];
        assign fall   = ~pin_in[i] & level_q[i];
        assign hit[i] = arm[i] & (pol[i] ? rise : fall);
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPINS = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] stat_q,
    output logic             irq_q
);
    logic [NPINS-1:0] stat_next;

    always_comb stat_next = (stat_q & ~clr) | hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_next;
            irq_q  <= |stat_next;
        end
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [7:0]       req_addr,
    input  logic [NPINS-1:0] req_wdata,
    output logic [NPINS-1:0] rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    acc_t             acc;
    logic             rd_any;
    logic [NPINS-1:0] drive_q, dir_q, pol_q, mask_q, gate_q;
    logic [NPINS-1:0] level_q, hit, stat_q, clr;
    logic [NPINS-1:0] arm, rd_mux, rdata_q;

    gpio_acc_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .acc       (acc),
        .rd_any    (rd_any)
    );

    gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wdata   (req_wdata),
        .drive_q (drive_q),
        .dir_q   (dir_q),
        .pol_q   (pol_q),
        .mask_q  (mask_q),
        .gate_q  (gate_q)
    );

    assign arm = dir_q & ~mask_q;

    gpio_edge_detect #(.NPINS(NPINS)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .pol     (pol_q),
        .arm     (arm),
        .level_q (level_q),
        .hit     (hit)
    );

    assign clr = (acc.wr && acc.sel == SEL_STAT) ? req_wdata : '0;

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .clr    (clr),
        .stat_q (stat_q),
        .irq_q  (irq)
    );

    always_comb begin
        case (acc.sel)
            SEL_LEVEL: rd_mux = level_q & gate_q;
            SEL_DRIVE: rd_mux = drive_q;
            SEL_DIR:   rd_mux = dir_q;
            SEL_POL:   rd_mux = pol_q;
            SEL_MASK:  rd_mux = mask_q;
            SEL_STAT:  rd_mux = stat_q;
            SEL_GATE:  rd_mux = gate_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_any) rdata_q <= acc.rd ? rd_mux : '0;
    end

    assign rdata   = rdata_q;
    assign pin_oe  = ~dir_q;
    assign pin_out = drive_q & ~dir_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 16
)(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_size,
    input logic [7:0]       req_addr,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] drive_q,
    input logic [NPINS-1:0] pol_q,
    input logic [NPINS-1:0] gate_q
);
    // R6
    arm_only_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q)) & ~($past(dir_q) & ~$past(mask_q))) == '0);

    // R8
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (|stat_q));

    // R3
    out_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    // R10
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size != 2'd1) |=>
            ($stable(dir_q) && $stable(drive_q) && $stable(pol_q)
             && $stable(mask_q) && $stable(gate_q)));

    // R7
    clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(stat_q) & ~stat_q) != '0) |->
            $past(req_valid && req_write && req_size == 2'd1
                  && req_addr == OFS_STAT));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat_q    (stat_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .drive_q   (drive_q),
    .pol_q     (pol_q),
    .gate_q    (gate_q)
);

// File: tb/gpio_edge_port_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_port_tb_top;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = 2'd1;
    logic [7:0]   req_addr = '0;
    logic [N-1:0] req_wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_port #(.NPINS(N)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [N-1:0] d, logic [1:0] sz = 2'd1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a;
        req_wdata = d; req_size = sz;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd1;
    endtask

    task automatic rd(logic [7:0] a, output logic [N-1:0] d,
                      input logic [1:0] sz = 2'd1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_size = 2'd1;
        d = rdata;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [N-1:0] exp);
        logic [N-1:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        check("R1 irq", irq, 0);
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 pin_out", pin_out, 16'h0000);
        rd_chk("R1 drive", 8'h04, 16'hFFFF);
        rd_chk("R1 dir", 8'h08, 16'hFFFF);
        rd_chk("R1 pol", 8'h0C, 16'hFFFF);
        rd_chk("R1 mask", 8'h10, 16'hFFFF);
        rd_chk("R1 stat", 8'h14, 16'h0000);
        rd_chk("R1 gate", 8'h18, 16'hFFFF);
        rd_chk("R1 level", 8'h00, 16'h0000);

        // R2 / R3 direction and drive
        wr(8'h04, 16'hA5C3);
        wr(8'h08, 16'h00FF);
        check("R2 pin_oe", pin_oe, 16'hFF00);
        check("R3 pin_out mix", pin_out, 16'hA5C3 & 16'hFF00);
        rd_chk("R3 drive readback", 8'h04, 16'hA5C3);
        wr(8'h08, 16'hFFFF);
        check("R2 all inputs", pin_oe, 16'h0000);
        check("R3 inputs drive 0", pin_out, 16'h0000);
        wr(8'h08, 16'h0000);
        check("R3 re-drive", pin_out, 16'hA5C3);
        wr(8'h08, 16'hFFFF);

        // R9 gated input read
        pin_in = 16'h3C5A;
        @(posedge clk); @(negedge clk);
        rd_chk("R9 ungated", 8'h00, 16'h3C5A);
        wr(8'h18, 16'h0FF0);
        rd_chk("R9 gated", 8'h00, 16'h3C5A & 16'h0FF0);
        wr(8'h18, 16'hFFFF);

        // R4 R5 R6 sweep over every pin and configuration
        for (int p = 0; p < N; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic         pol, din, msk, pre;
                logic [N-1:0] exp;
                pol = c[0]; din = c[1]; msk = c[2];
                pre = ~pol;
                wr(8'h10, 16'hFFFF);
                wr(8'h08, din ? 16'hFFFF : ~(16'h1 << p));
                wr(8'h0C, pol ? 16'hFFFF : 16'h0000);
                pin_in = pre ? 16'hFFFF : 16'h0000;
                @(posedge clk); @(negedge clk);
                wr(8'h14, 16'hFFFF);
                wr(8'h10, msk ? 16'hFFFF : ~(16'h1 << p));
                pin_in[p] = ~pre;
                @(posedge clk); @(negedge clk);
                exp = (din && !msk) ? (16'h1 << p) : 16'h0;
                check(pol ? "R4 rising/R6" : "R5 falling/R6", irq, |exp);
                rd_chk(pol ? "R4 stat" : "R5 stat", 8'h14, exp);
                wr(8'h14, 16'hFFFF);
                pin_in[p] = pre;
                @(posedge clk); @(negedge clk);
                rd_chk("R5 opposite edge ignored", 8'h14, 16'h0000);
            end
        end

        // R7 / R8 clearing and collision
        wr(8'h10, 16'hFFFF);
        wr(8'h08, 16'hFFFF);
        wr(8'h0C, 16'hFFFF);
        pin_in = 16'h0000;
        @(posedge clk); @(negedge clk);
        wr(8'h14, 16'hFFFF);
        wr(8'h10, 16'hFFFC);
        pin_in = 16'h0003;
        @(posedge clk); @(negedge clk);
        check("R8 irq rise", irq, 1);
        rd_chk("R7 both set", 8'h14, 16'h0003);
        wr(8'h14, 16'h0001);
        rd_chk("R7 partial clear", 8'h14, 16'h0002);
        check("R8 irq held", irq, 1);
        wr(8'h14, 16'h0002);
        check("R8 irq fall", irq, 0);
        rd_chk("R7 all clear", 8'h14, 16'h0000);
        pin_in = 16'h0000;
        @(posedge clk); @(negedge clk);
        pin_in = 16'h0001;
        wr(8'h14, 16'h0001);
        rd_chk("R7 set wins", 8'h14, 16'h0001);
        check("R8 irq after collision", irq, 1);
        wr(8'h14, 16'hFFFF);

        // R10 ignored accesses
        wr(8'h08, 16'h1234);
        wr(8'h00, 16'h0000);
        wr(8'h1C, 16'h0000);
        wr(8'h08, 16'h0000, 2'd2);
        wr(8'h08, 16'h0000, 2'd0);
        rd_chk("R10 wrong width write", 8'h08, 16'h1234);
        rd_chk("R10 level unchanged", 8'h00, 16'h0001);
        rd_chk("R10 undefined read", 8'h1C, 16'h0000);
        rd(8'h08, v, 2'd0);
        check("R10 narrow read", v, 16'h0000);

        // R11 registered read latency and hold
        rd(8'h08, v);
        check("R11 read data", v, 16'h1234);
        @(posedge clk); @(negedge clk);
        check("R11 hold", rdata, 16'h1234);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule